// File: doc/BRIEF.md
# Display control and interrupt registers

This block is the software-visible register file of a simple framebuffer controller. A byte-wide register bus reaches a control byte, a status byte and a bank of general-purpose bytes that other display logic reads. A frame-refresh tick from the scan-out side can raise a level interrupt. Software enables that interrupt through the control byte and acknowledges it by writing the status byte.

Status reads report the live pending flag merged with a fixed identification pattern that tells software which monitor and colour configuration is present. Reads are registered: read data and the error flag appear in the cycle after the request. Offsets that map to nothing read as zero and raise a one-cycle error pulse.

Top module: `fbctl_regs`

## Requirements
- R1: After reset, the control byte and every general-purpose byte read as zero, the pending flag is clear, `irq` is low, and a status read returns only the identity constant (0x61 by default).
- R2: Offset 0 holds the control byte. All eight bits are read/write, so any written value reads back unchanged.
- R3: A cycle with `frame_tick` high while control bit 7 is set makes the pending flag (status bit 7) and `irq` high from the next cycle. A tick while control bit 7 is clear changes nothing, whatever the other control bits hold.
- R4: Any write to offset 1, the status byte, clears the pending flag and drops `irq` from the next cycle. The written data is not stored.
- R5: A status read returns the pending flag in bit 7, ORed with the identity constant in bits 6:0.
- R6: Offsets 0x10 through 0x1F are sixteen independent read/write bytes, indexed by the offset minus 0x10.
- R7: A read of an offset from 0x02 to 0x0F returns zero and pulses `bus_err` high for exactly one cycle. Writes to those offsets change no register.
- R8: When a tick that would set the pending flag and a status write fall in the same cycle, the flag ends up set and `irq` stays high.
- R9: `bus_rdata` and `bus_err` change in the cycle after a read request. `bus_rdata` then holds its value until the next read.
- R10: Clearing control bit 7 while an interrupt is pending leaves the pending flag and `irq` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a read of an unmapped offset |
| frame_tick | input | 1 | One-cycle frame-refresh event |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench fires a tick and a status write in the same cycle. A design that gave the clear priority would lose that frame's interrupt. It clears the enable bit while an interrupt is pending, which catches a design that derives `irq` combinationally from the enable bit. It writes several patterns to the status byte and reads them back, which exposes a design that stores the written value or lets it leak past the identity constant. It sweeps every unmapped offset with writes and reads, then rereads the real registers. This catches decode holes that alias into the general-purpose bank or leave the error pulse stuck high.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_CTRL = 2'd1,
      RG_STAT = 2'd2,
      RG_GP   = 2'd3
   } fbctl_region_e;

   localparam int unsigned GP_BASE = 16;
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
   import fbctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned GP_NUM   = 16,
   parameter int unsigned GP_IDX_W = 4
) (
   input  logic [ADDR_W-1:0]   addr,
   output fbctl_region_e       region,
   output logic [GP_IDX_W-1:0] gp_idx
);
   localparam logic [ADDR_W-1:0] GP_LO   = ADDR_W'(GP_BASE);
   localparam logic [ADDR_W-1:0] GP_CNT  = ADDR_W'(GP_NUM);
   localparam logic [ADDR_W-1:0] OFS_CTL = '0;
   localparam logic [ADDR_W-1:0] OFS_STA = ADDR_W'(1);

   logic [ADDR_W-1:0] ofs;

   always_comb begin
      ofs    = addr - GP_LO;
      gp_idx = ofs[GP_IDX_W-1:0];
      if (addr == OFS_CTL)
         region = RG_CTRL;
      else if (addr == OFS_STA)
         region = RG_STAT;
      else if ((addr >= GP_LO) && (ofs < GP_CNT))
         region = RG_GP;
      else
         region = RG_NONE;
   end
endmodule

// File: rtl/fbctl_irq.sv
module fbctl_irq #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned IRQ_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] ctrl,
   input  logic              ack,
   output logic              pend
);
   logic arm;

   assign arm = tick & ctrl[IRQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (arm)
         pend <= 1'b1;
      else if (ack)
         pend <= 1'b0;
   end
endmodule

// File: rtl/fbctl_gpbank.sv
module fbctl_gpbank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned GP_NUM   = 16,
   parameter int unsigned GP_IDX_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [GP_IDX_W-1:0]      idx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [GP_NUM*DATA_W-1:0] flat
);
   for (genvar g = 0; g < GP_NUM; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flat[g*DATA_W +: DATA_W] <= '0;
         else if (we && (idx == GP_IDX_W'(g)))
            flat[g*DATA_W +: DATA_W] <= wdata;
      end
   end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
   import fbctl_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 5,
   parameter int unsigned       DATA_W  = 8,
   parameter int unsigned       GP_NUM  = 16,
   parameter int unsigned       IRQ_BIT = 7,
   parameter logic [DATA_W-1:0] STAT_ID = 8'h61
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic              frame_tick,
   output logic              irq
);
   localparam int unsigned GP_IDX_W = (GP_NUM > 1) ? $clog2(GP_NUM) : 1;

   if (IRQ_BIT >= DATA_W) begin : g_bad_bit
      $error("fbctl_regs: IRQ_BIT outside data width");
   end
   if (STAT_ID[IRQ_BIT] != 1'b0) begin : g_bad_id
      $error("fbctl_regs: STAT_ID overlaps pending bit");
   end
   if ((GP_BASE + GP_NUM) > (2 ** ADDR_W)) begin : g_bad_win
      $error("fbctl_regs: general bank exceeds address window");
   end
   if (GP_NUM < 1) begin : g_bad_num
      $error("fbctl_regs: GP_NUM must be at least one");
   end

   fbctl_region_e             region;
   logic [GP_IDX_W-1:0]       gp_idx;
   logic [DATA_W-1:0]         ctrl_q;
   logic                      pend;
   logic [GP_NUM*DATA_W-1:0]  gp_flat;
   logic                      wr_go;
   logic                      rd_go;
   logic [DATA_W-1:0]         rd_val;

   assign wr_go = bus_sel &  bus_wr;
   assign rd_go = bus_sel & ~bus_wr;

   fbctl_decode #(
      .ADDR_W  (ADDR_W),
      .GP_NUM  (GP_NUM),
      .GP_IDX_W(GP_IDX_W)
   ) u_dec (
      .addr  (bus_addr),
      .region(region),
      .gp_idx(gp_idx)
   );

   fbctl_irq #(
      .DATA_W (DATA_W),
      .IRQ_BIT(IRQ_BIT)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (frame_tick),
      .ctrl (ctrl_q),
      .ack  (wr_go && (region == RG_STAT)),
      .pend (pend)
   );

   fbctl_gpbank #(
      .DATA_W  (DATA_W),
      .GP_NUM  (GP_NUM),
      .GP_IDX_W(GP_IDX_W)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_go && (region == RG_GP)),
      .idx  (gp_idx),
      .wdata(bus_wdata),
      .flat (gp_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_go && (region == RG_CTRL))
         ctrl_q <= bus_wdata;
   end

   always_comb begin
      case (region)
         RG_CTRL: rd_val = ctrl_q;
         RG_STAT: rd_val = STAT_ID | (DATA_W'(pend) << IRQ_BIT);
         RG_GP:   rd_val = gp_flat[gp_idx*DATA_W +: DATA_W];
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= rd_go && (region == RG_NONE);
         if (rd_go)
            bus_rdata <= rd_val;
      end
   end

   assign irq = pend;
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
   parameter int unsigned       ADDR_W  = 5,
   parameter int unsigned       DATA_W  = 8,
   parameter int unsigned       GP_NUM  = 16,
   parameter int unsigned       IRQ_BIT = 7,
   parameter logic [DATA_W-1:0] STAT_ID = 8'h61
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic              frame_tick,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl_q
);
   logic set_req, clr_req, rd_stat, rd_hole;

   assign set_req = frame_tick && ctrl_q[IRQ_BIT];
   assign clr_req = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));
   assign rd_stat = bus_sel && !bus_wr && (bus_addr == ADDR_W'(1));
   assign rd_hole = bus_sel && !bus_wr && (int'(bus_addr) >= 2) &&
                    ((int'(bus_addr) < 16) || (int'(bus_addr) >= 16 + int'(GP_NUM)));

   a_r3_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> irq);

   a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_req) |=> !irq);

   a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req && !clr_req) |=> (irq == $past(irq)));

   a_r5_status_id: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> (((bus_rdata & STAT_ID) == STAT_ID) && (bus_rdata[IRQ_BIT] == $past(irq))));

   a_r7_hole_err: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hole |=> (bus_err && (bus_rdata == '0)));

   a_r7_err_only_hole: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hole |=> !bus_err);
endmodule

bind fbctl_regs fbctl_regs_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .GP_NUM (GP_NUM),
   .IRQ_BIT(IRQ_BIT),
   .STAT_ID(STAT_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .frame_tick(frame_tick),
   .irq       (irq),
   .ctrl_q    (ctrl_q)
);

// File: tb/fbctl_regs_tb.sv
`timescale 1ns/1ps
module fbctl_regs_tb;
   localparam logic [7:0] ID = 8'h61;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_err;
   logic       frame_tick = 1'b0;
   logic       irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] rd_data;
   logic       rd_err;

   always #10 clk = ~clk;

   fbctl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .frame_tick(frame_tick), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      rd_data = bus_rdata;
      rd_err  = bus_err;
   endtask

   task automatic tick();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   function automatic logic [7:0] gpat(input int i, input int k);
      return 8'((i * 37 + 5 + k * 11) & 8'hFF);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(5'h00); chk("R1 ctrl", rd_data, 8'h00);
      rd(5'h01); chk("R1 status", rd_data, ID);
      for (int i = 0; i < 16; i++) begin
         rd(5'(16 + i)); chk("R1 gp", rd_data, 8'h00);
      end

      for (int v = 0; v < 256; v++) begin
         wr(5'h00, 8'(v)); rd(5'h00); chk("R2 ctrl rw", rd_data, 8'(v));
      end
      wr(5'h00, 8'h00);

      for (int k = 0; k < 2; k++) begin
         for (int i = 0; i < 16; i++) wr(5'(16 + i), gpat(i, k));
         for (int i = 0; i < 16; i++) begin
            rd(5'(16 + i)); chk("R6 gp", rd_data, gpat(i, k));
         end
      end

      wr(5'h00, 8'h5A);
      for (int a = 2; a < 16; a++) begin
         wr(5'(a), 8'hFF);
         rd(5'(a));
         chk("R7 hole data", rd_data, 8'h00);
         chk("R7 hole err", {7'd0, rd_err}, 8'h01);
         @(negedge clk);
         chk("R9 err pulse", {7'd0, bus_err}, 8'h00);
      end
      rd(5'h00); chk("R7 ctrl untouched", rd_data, 8'h5A);
      for (int i = 0; i < 16; i++) begin
         rd(5'(16 + i)); chk("R7 gp untouched", rd_data, gpat(i, 1));
      end
      rd(5'h11);
      repeat (3) @(negedge clk);
      chk("R9 rdata held", bus_rdata, gpat(1, 1));
      chk("R9 no err", {7'd0, bus_err}, 8'h00);

      wr(5'h00, 8'h00); tick();
      chk("R3 tick disabled", {7'd0, irq}, 8'h00);
      wr(5'h00, 8'h7F); tick();
      chk("R3 other bits", {7'd0, irq}, 8'h00);
      rd(5'h01); chk("R3 status idle", rd_data, ID);
      wr(5'h00, 8'h80); tick();
      chk("R3 tick enabled", {7'd0, irq}, 8'h01);
      rd(5'h01); chk("R5 status pending", rd_data, ID | 8'h80);

      wr(5'h00, 8'h00);
      chk("R10 hold after disable", {7'd0, irq}, 8'h01);
      tick();
      chk("R10 hold through tick", {7'd0, irq}, 8'h01);

      wr(5'h01, 8'h00);
      chk("R4 clear", {7'd0, irq}, 8'h00);
      rd(5'h01); chk("R4 status cleared", rd_data, ID);
      for (int p = 0; p < 4; p++) begin
         wr(5'h01, 8'(8'hFF >> (2 * p)));
         rd(5'h01); chk("R4 data not stored", rd_data, ID);
      end

      wr(5'h00, 8'h80); tick();
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h01; bus_wdata = 8'h80; frame_tick = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; frame_tick = 1'b0;
      chk("R8 set wins", {7'd0, irq}, 8'h01);
      rd(5'h01); chk("R8 status", rd_data, ID | 8'h80);
      wr(5'h01, 8'h12);
      chk("R4 clear after R8", {7'd0, irq}, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule